// File: doc/BRIEF.md
# Display Video Input Sampling Front End

This block sits between the parallel output of a display controller (frame sync, line sync, data enable and a pixel bus) and the packet builder of a serial display link. It registers every input once and converts the three control lines to an internal active-high form, each according to its own polarity setting. It ignores all traffic until the first frame-sync edge after reset, so a stream never begins in the middle of a frame. Once armed, it passes exactly one whole pixel per data-enable cycle, cut into packet payload segments with start and end strobes.

The configured line length and segment size follow the multiplicity rule of the selected color coding. Bits that the rule forbids are forced to zero. A line that ends early raises a sticky error. Pixels beyond the configured length are dropped until data enable falls.

Shutdown and color-mode requests are latched from a register write and forwarded only on a frame-sync edge. After a shutdown has been forwarded, a further whole frame must pass before the block reports that the video source may be stopped.

Top module: `vid_sample_frontend`

## Requirements
- R1: Each control input (frame sync, line sync, data enable) has its own polarity bit: 1 means active high, 0 means active low. `out_vsync` and `out_hsync` repeat the active-high form of the sync inputs once armed, two clocks after the input.
- R2: After reset, no pixel is accepted and `out_vsync`/`out_hsync` stay low until the first cycle in which frame sync is active after being inactive. That cycle counts as such an edge if frame sync is already active in the first sampled cycle. `armed` then stays high until reset.
- R3: While armed, each cycle with data enable active inside a line gives `out_valid` high with `out_pixel` equal to the input pixel, two clocks later. `out_pixel` is zero when `out_valid` is low.
- R4: The line length is taken as configured and does not adapt to the input. The pixel that reaches the effective length raises `out_line_end`. Further pixels are dropped until data enable goes inactive for a cycle.
- R5: Coding codes are: 0 = 16-bit, 1 = 18-bit loose, 2 = 24-bit, 3 = packed pixel stream, 4 = 18-bit tight. Codes 5 to 7 behave like code 2. Under code 4, bits [1:0] of both the line length and the segment size are forced to zero.
- R6: Under code 3, bit 0 of the segment size is forced to zero. Under codes 0, 1, 2 and 5 to 7, both sizes are used as written.
- R7: `out_pkt_start` marks the first pixel of each segment. `out_pkt_end` marks the pixel that completes the effective segment size, or the last pixel of the line, whichever comes first. An effective segment size of zero makes the whole line one segment.
- R8: If data enable goes inactive inside a line before the effective length is reached, `err_short_line` rises and stays high until reset. The next data-enable run starts a new line at pixel zero.
- R9: When the effective line length is zero, no pixel is accepted.
- R10: A command write latches the shutdown and color-mode values and sets `cmd_pending`. At the next frame-sync edge the latched values appear on `out_shutdown`/`out_colmode`, `cmd_issue` pulses for one cycle and `cmd_pending` clears. No frame-sync edge means no forwarding.
- R11: A write sampled in the same cycle as a frame-sync edge does not take part in that edge. Any earlier pending command is forwarded, and the new one stays pending for the next edge.
- R12: `safe_to_stop` rises at the first frame-sync edge after the one that forwarded a shutdown value of 1. It clears when a command with shutdown 0 is forwarded. A new shutdown command restarts the one-frame wait.

Frame-sync edge tracking (two states): **UNARMED** moves to **WAIT_LINE** on the first edge (transition *arm*).

Line segmenter states:
- **WAIT_LINE** moves to **IN_LINE** on an accepted pixel that is not the last (*line_open*). It moves to **DRAIN** on a single-pixel line (*line_done*).
- **IN_LINE** moves to **DRAIN** on the last pixel (*line_done*). It moves to **WAIT_LINE** when data enable drops (*line_short*).
- **DRAIN** moves to **WAIT_LINE** when data enable is inactive (*line_close*).

Stop tracker states:
- **STOP_IDLE** moves to **STOP_WAIT_FRAME** when a shutdown of 1 is forwarded (*shut_issued*).
- **STOP_WAIT_FRAME** moves to **STOP_SAFE** at the next edge with no forwarding (*frame_seen*).
- Forwarding shutdown 0 returns either state to **STOP_IDLE** (*shut_cancel*).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_vsync_pol | input | 1 | Frame-sync active level (1 = high) |
| cfg_hsync_pol | input | 1 | Line-sync active level (1 = high) |
| cfg_de_pol | input | 1 | Data-enable active level (1 = high) |
| cfg_coding | input | 3 | Color coding code |
| cfg_line_px | input | SIZE_W | Pixels per line as written |
| cfg_pkt_px | input | SIZE_W | Pixels per segment as written |
| vid_vsync | input | 1 | Frame sync from the controller |
| vid_hsync | input | 1 | Line sync from the controller |
| vid_de | input | 1 | Data enable from the controller |
| vid_pixel | input | PIX_W | Pixel bus |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_shutdown | input | 1 | Shutdown value being written |
| cmd_colmode | input | 1 | Color-mode value being written |
| armed | output | 1 | First frame-sync edge has been seen |
| out_vsync | output | 1 | Active-high frame sync, gated by arming |
| out_hsync | output | 1 | Active-high line sync, gated by arming |
| out_valid | output | 1 | Pixel accepted |
| out_pixel | output | PIX_W | Accepted pixel |
| out_pkt_start | output | 1 | First pixel of a segment |
| out_pkt_end | output | 1 | Last pixel of a segment |
| out_line_end | output | 1 | Last pixel of a line |
| err_short_line | output | 1 | Sticky short-line error |
| cmd_pending | output | 1 | A written command awaits a frame-sync edge |
| cmd_issue | output | 1 | One-cycle strobe when a command is forwarded |
| out_shutdown | output | 1 | Forwarded shutdown value |
| out_colmode | output | 1 | Forwarded color-mode value |
| safe_to_stop | output | 1 | One full frame has passed since shutdown |

## Verification
The bench builds the block with SIZE_W = 6 and PIX_W = 12. This keeps line and segment lengths short enough that many complete frames fit in one run. At the same time it leaves room for lengths that need the forced low bits of codes 3 and 4, for segment sizes larger than the line, and for an effective line length of zero. Random data-enable run lengths just under and just over the configured length drive the short-line error and the drain path. Command writes placed on and between frame-sync edges reach the overlap rule and the shutdown wait.

// File: rtl/vsf_pkg.sv
package vsf_pkg;

    typedef enum logic [2:0] {
        CODING_16       = 3'd0,
        CODING_18_LOOSE = 3'd1,
        CODING_24       = 3'd2,
        CODING_STREAM   = 3'd3,
        CODING_18_TIGHT = 3'd4
    } coding_t;

    typedef enum logic [1:0] {
        SEG_UNARMED = 2'd0,
        SEG_WAIT    = 2'd1,
        SEG_LINE    = 2'd2,
        SEG_DRAIN   = 2'd3
    } seg_state_t;

    typedef enum logic [1:0] {
        STOP_IDLE       = 2'd0,
        STOP_WAIT_FRAME = 2'd1,
        STOP_SAFE       = 2'd2
    } stop_state_t;

    localparam int NUM_CTL = 3;

endpackage

// File: rtl/vsf_in_stage.sv
module vsf_in_stage #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       pol,
    input  logic [2:0]       raw_ctl,
    input  logic [PIX_W-1:0] raw_pix,
    input  logic             raw_wr,
    input  logic             raw_sd,
    input  logic             raw_cm,
    output logic             s_vs,
    output logic             s_hs,
    output logic             s_de,
    output logic [PIX_W-1:0] s_pix,
    output logic             s_wr,
    output logic             s_sd,
    output logic             s_cm,
    output logic             vs_rise
);
    import vsf_pkg::*;

    logic [NUM_CTL-1:0] norm;
    logic [NUM_CTL-1:0] ctl_q;
    logic               vs_prev;

    // one normaliser per control line; bit 0 frame sync, 1 line sync, 2 enable
    for (genvar g = 0; g < NUM_CTL; g++) begin : g_norm
        assign norm[g] = pol[g] ? raw_ctl[g] : ~raw_ctl[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            s_pix   <= '0;
            s_wr    <= 1'b0;
            s_sd    <= 1'b0;
            s_cm    <= 1'b0;
            vs_prev <= 1'b0;
        end else begin
            ctl_q   <= norm;
            s_pix   <= raw_pix;
            s_wr    <= raw_wr;
            s_sd    <= raw_sd;
            s_cm    <= raw_cm;
            vs_prev <= ctl_q[0];
        end
    end

    assign s_vs    = ctl_q[0];
    assign s_hs    = ctl_q[1];
    assign s_de    = ctl_q[2];
    assign vs_rise = ctl_q[0] & ~vs_prev;

endmodule

// File: rtl/vsf_size_rule.sv
module vsf_size_rule #(
    parameter int SIZE_W = 12
) (
    input  logic [2:0]        coding,
    input  logic [SIZE_W-1:0] line_px,
    input  logic [SIZE_W-1:0] pkt_px,
    output logic [SIZE_W-1:0] eff_line,
    output logic [SIZE_W-1:0] eff_pkt
);
    import vsf_pkg::*;

    localparam logic [SIZE_W-1:0] MASK_EVEN = ~(SIZE_W'(1));
    localparam logic [SIZE_W-1:0] MASK_QUAD = ~(SIZE_W'(3));

    always_comb begin
        eff_line = line_px;
        eff_pkt  = pkt_px;
        case (coding_t'(coding))
            CODING_STREAM: begin
                eff_pkt = pkt_px & MASK_EVEN;
            end
            CODING_18_TIGHT: begin
                eff_line = line_px & MASK_QUAD;
                eff_pkt  = pkt_px & MASK_QUAD;
            end
            default: begin
                eff_line = line_px;
                eff_pkt  = pkt_px;
            end
        endcase
    end

endmodule

// File: rtl/vsf_line_seg.sv
module vsf_line_seg #(
    parameter int PIX_W  = 24,
    parameter int SIZE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vs_rise,
    input  logic              s_vs,
    input  logic              s_hs,
    input  logic              s_de,
    input  logic [PIX_W-1:0]  s_pix,
    input  logic [SIZE_W-1:0] eff_line,
    input  logic [SIZE_W-1:0] eff_pkt,
    output logic              armed,
    output logic              out_vsync,
    output logic              out_hsync,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pixel,
    output logic              out_pkt_start,
    output logic              out_pkt_end,
    output logic              out_line_end,
    output logic              err_short_line
);
    import vsf_pkg::*;

    localparam int CNT_W = SIZE_W + 1;

    seg_state_t        state, state_nx;
    logic [SIZE_W-1:0] line_cnt;
    logic [SIZE_W-1:0] pkt_cnt;
    logic              accept;
    logic              short_line;
    logic              last_px;
    logic              seg_full;
    logic              seg_end;
    logic              arm_now;

    always_comb begin
        accept     = 1'b0;
        short_line = 1'b0;
        unique case (state)
            SEG_WAIT:  accept = s_de && (eff_line != '0);
            SEG_LINE: begin
                accept     = s_de;
                short_line = !s_de;
            end
            default: accept = 1'b0;
        endcase
        last_px  = accept && (CNT_W'(line_cnt) + CNT_W'(1) == CNT_W'(eff_line));
        seg_full = (eff_pkt != '0) && (CNT_W'(pkt_cnt) + CNT_W'(1) == CNT_W'(eff_pkt));
        seg_end  = accept && (last_px || seg_full);
        arm_now  = (state != SEG_UNARMED) || vs_rise;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEG_UNARMED: if (vs_rise) state_nx = SEG_WAIT;               // arm
            SEG_WAIT: begin
                if (last_px)     state_nx = SEG_DRAIN;                   // line_done
                else if (accept) state_nx = SEG_LINE;                    // line_open
            end
            SEG_LINE: begin
                if (short_line)   state_nx = SEG_WAIT;                   // line_short
                else if (last_px) state_nx = SEG_DRAIN;                  // line_done
            end
            SEG_DRAIN: if (!s_de) state_nx = SEG_WAIT;                   // line_close
            default: state_nx = SEG_UNARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEG_UNARMED;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_cnt       <= '0;
            pkt_cnt        <= '0;
            out_valid      <= 1'b0;
            out_pixel      <= '0;
            out_pkt_start  <= 1'b0;
            out_pkt_end    <= 1'b0;
            out_line_end   <= 1'b0;
            out_vsync      <= 1'b0;
            out_hsync      <= 1'b0;
            err_short_line <= 1'b0;
        end else begin
            out_valid     <= accept;
            out_pixel     <= accept ? s_pix : '0;
            out_pkt_start <= accept && (pkt_cnt == '0);
            out_pkt_end   <= seg_end;
            out_line_end  <= last_px;
            out_vsync     <= s_vs && arm_now;
            out_hsync     <= s_hs && arm_now;
            if (short_line) begin
                err_short_line <= 1'b1;
                line_cnt       <= '0;
                pkt_cnt        <= '0;
            end else if (accept) begin
                line_cnt <= last_px ? '0 : line_cnt + SIZE_W'(1);
                pkt_cnt  <= seg_end ? '0 : pkt_cnt + SIZE_W'(1);
            end
        end
    end

    assign armed = (state != SEG_UNARMED);

    AST_NO_PIXEL_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEG_UNARMED) |=> !out_valid);                          // R2
    AST_START_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_pkt_start |-> out_valid);                                    // R7
    AST_LINE_END_CLOSES_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        out_line_end |-> out_pkt_end);                                   // R7
    AST_LINE_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_line != '0) |-> (line_cnt < eff_line));                     // R4
    AST_PKT_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_pkt != '0) |-> (pkt_cnt < eff_pkt));                        // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_short_line |=> err_short_line);                              // R8
    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);                                                // R2

endmodule

// File: rtl/vsf_cmd_ctrl.sv
module vsf_cmd_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic vs_rise,
    input  logic s_wr,
    input  logic s_sd,
    input  logic s_cm,
    output logic cmd_pending,
    output logic cmd_issue,
    output logic out_shutdown,
    output logic out_colmode,
    output logic safe_to_stop
);
    import vsf_pkg::*;

    stop_state_t stop_st, stop_nx;
    logic        lat_sd;
    logic        lat_cm;
    logic        fire;

    assign fire = vs_rise && cmd_pending;

    always_comb begin
        stop_nx = stop_st;
        if (fire) begin
            stop_nx = lat_sd ? STOP_WAIT_FRAME : STOP_IDLE;              // shut_issued / shut_cancel
        end else if (vs_rise) begin
            unique case (stop_st)
                STOP_WAIT_FRAME: stop_nx = STOP_SAFE;                    // frame_seen
                default:         stop_nx = stop_st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stop_st <= STOP_IDLE;
        else        stop_st <= stop_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_sd       <= 1'b0;
            lat_cm       <= 1'b0;
            cmd_pending  <= 1'b0;
            cmd_issue    <= 1'b0;
            out_shutdown <= 1'b0;
            out_colmode  <= 1'b0;
        end else begin
            cmd_issue <= fire;
            if (fire) begin
                out_shutdown <= lat_sd;
                out_colmode  <= lat_cm;
            end
            if (s_wr) begin
                lat_sd      <= s_sd;
                lat_cm      <= s_cm;
                cmd_pending <= 1'b1;
            end else if (fire) begin
                cmd_pending <= 1'b0;
            end
        end
    end

    assign safe_to_stop = (stop_st == STOP_SAFE);

    AST_ISSUE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_issue |-> $past(vs_rise));                                   // R10
    AST_PENDING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_rise && cmd_pending && !s_wr) |=> !cmd_pending);             // R10
    AST_WRITE_STAYS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        s_wr |=> cmd_pending);                                           // R11
    AST_SAFE_NEEDS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        safe_to_stop |-> out_shutdown);                                  // R12

endmodule

// File: rtl/vid_sample_frontend.sv
module vid_sample_frontend #(
    parameter int PIX_W  = 24,
    parameter int SIZE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_vsync_pol,
    input  logic              cfg_hsync_pol,
    input  logic              cfg_de_pol,
    input  logic [2:0]        cfg_coding,
    input  logic [SIZE_W-1:0] cfg_line_px,
    input  logic [SIZE_W-1:0] cfg_pkt_px,
    input  logic              vid_vsync,
    input  logic              vid_hsync,
    input  logic              vid_de,
    input  logic [PIX_W-1:0]  vid_pixel,
    input  logic              cmd_wr,
    input  logic              cmd_shutdown,
    input  logic              cmd_colmode,
    output logic              armed,
    output logic              out_vsync,
    output logic              out_hsync,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pixel,
    output logic              out_pkt_start,
    output logic              out_pkt_end,
    output logic              out_line_end,
    output logic              err_short_line,
    output logic              cmd_pending,
    output logic              cmd_issue,
    output logic              out_shutdown,
    output logic              out_colmode,
    output logic              safe_to_stop
);

    logic              s_vs, s_hs, s_de, s_wr, s_sd, s_cm, vs_rise;
    logic [PIX_W-1:0]  s_pix;
    logic [SIZE_W-1:0] eff_line, eff_pkt;

    vsf_in_stage #(.PIX_W(PIX_W)) in_stage_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pol     ({cfg_de_pol, cfg_hsync_pol, cfg_vsync_pol}),
        .raw_ctl ({vid_de, vid_hsync, vid_vsync}),
        .raw_pix (vid_pixel),
        .raw_wr  (cmd_wr),
        .raw_sd  (cmd_shutdown),
        .raw_cm  (cmd_colmode),
        .s_vs    (s_vs),
        .s_hs    (s_hs),
        .s_de    (s_de),
        .s_pix   (s_pix),
        .s_wr    (s_wr),
        .s_sd    (s_sd),
        .s_cm    (s_cm),
        .vs_rise (vs_rise)
    );

    vsf_size_rule #(.SIZE_W(SIZE_W)) size_rule_i (
        .coding   (cfg_coding),
        .line_px  (cfg_line_px),
        .pkt_px   (cfg_pkt_px),
        .eff_line (eff_line),
        .eff_pkt  (eff_pkt)
    );

    vsf_line_seg #(.PIX_W(PIX_W), .SIZE_W(SIZE_W)) line_seg_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .vs_rise        (vs_rise),
        .s_vs           (s_vs),
        .s_hs           (s_hs),
        .s_de           (s_de),
        .s_pix          (s_pix),
        .eff_line       (eff_line),
        .eff_pkt        (eff_pkt),
        .armed          (armed),
        .out_vsync      (out_vsync),
        .out_hsync      (out_hsync),
        .out_valid      (out_valid),
        .out_pixel      (out_pixel),
        .out_pkt_start  (out_pkt_start),
        .out_pkt_end    (out_pkt_end),
        .out_line_end   (out_line_end),
        .err_short_line (err_short_line)
    );

    vsf_cmd_ctrl cmd_ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .vs_rise      (vs_rise),
        .s_wr         (s_wr),
        .s_sd         (s_sd),
        .s_cm         (s_cm),
        .cmd_pending  (cmd_pending),
        .cmd_issue    (cmd_issue),
        .out_shutdown (out_shutdown),
        .out_colmode  (out_colmode),
        .safe_to_stop (safe_to_stop)
    );

endmodule

// File: tb/vid_sample_frontend_tb_top.sv
`timescale 1ns/1ps
module vid_sample_frontend_tb_top;

    localparam int PIX_W  = 12;
    localparam int SIZE_W = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic              cfg_vsync_pol, cfg_hsync_pol, cfg_de_pol;
    logic [2:0]        cfg_coding;
    logic [SIZE_W-1:0] cfg_line_px, cfg_pkt_px;
    logic              vid_vsync, vid_hsync, vid_de;
    logic [PIX_W-1:0]  vid_pixel;
    logic              cmd_wr, cmd_shutdown, cmd_colmode;
    logic              armed, out_vsync, out_hsync, out_valid;
    logic [PIX_W-1:0]  out_pixel;
    logic              out_pkt_start, out_pkt_end, out_line_end, err_short_line;
    logic              cmd_pending, cmd_issue, out_shutdown, out_colmode, safe_to_stop;

    vid_sample_frontend #(.PIX_W(PIX_W), .SIZE_W(SIZE_W)) dut_i (.*);

    typedef struct packed {
        logic             arm, vs, hs, valid;
        logic [PIX_W-1:0] pix;
        logic             ps, pe, le, err, pend, issue, shut, col, safe;
    } exp_t;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag      = "R2";

    exp_t exp_d1, exp_d2;
    bit   ok_d1, ok_d2;

    // reference state
    bit m_armed, m_prev_vs, m_err, m_pend, m_lat_s, m_lat_c, m_shut, m_col;
    int m_st, m_lcnt, m_pcnt, m_stage;

    function automatic int effl();
        if (cfg_coding == 3'd4) return int'(cfg_line_px) & ~3;
        return int'(cfg_line_px);
    endfunction

    function automatic int effp();
        if (cfg_coding == 3'd4) return int'(cfg_pkt_px) & ~3;
        if (cfg_coding == 3'd3) return int'(cfg_pkt_px) & ~1;
        return int'(cfg_pkt_px);
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] want,
                       input string name, input string req);
        n_checks++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s (%s) %s: actual %0h expected %0h at %0t",
                     req, tag, name, got, want, $time);
        end
    endtask

    task automatic check_out(input exp_t e);
        chk(armed, e.arm, "armed", "R2");
        chk(out_vsync, e.vs, "out_vsync", "R1");
        chk(out_hsync, e.hs, "out_hsync", "R1");
        chk(out_valid, e.valid, "out_valid", "R3");
        chk(32'(out_pixel), 32'(e.pix), "out_pixel", "R3");
        chk(out_pkt_start, e.ps, "out_pkt_start", "R7");
        chk(out_pkt_end, e.pe, "out_pkt_end", "R7");
        chk(out_line_end, e.le, "out_line_end", "R4");
        chk(err_short_line, e.err, "err_short_line", "R8");
        chk(cmd_pending, e.pend, "cmd_pending", "R10");
        chk(cmd_issue, e.issue, "cmd_issue", "R10");
        chk(out_shutdown, e.shut, "out_shutdown", "R10");
        chk(out_colmode, e.col, "out_colmode", "R10");
        chk(safe_to_stop, e.safe, "safe_to_stop", "R12");
    endtask

    function automatic exp_t model(input bit vs_a, input bit hs_a, input bit de_a,
                                   input logic [PIX_W-1:0] pix,
                                   input bit wr, input bit sd, input bit cm);
        exp_t e;
        bit rise, arm_now, acc, last;
        int el, ep;
        e = '0;
        el = effl();
        ep = effp();
        rise = vs_a && !m_prev_vs;
        m_prev_vs = vs_a;
        arm_now = m_armed || rise;
        e.vs = vs_a && arm_now;
        e.hs = hs_a && arm_now;
        acc = 1'b0;
        if (m_armed) begin
            case (m_st)
                0: acc = de_a && (el != 0);
                1: if (de_a) acc = 1'b1;
                   else begin m_err = 1'b1; m_st = 0; m_lcnt = 0; m_pcnt = 0; end
                default: if (!de_a) m_st = 0;
            endcase
        end
        if (acc) begin
            last    = (m_lcnt + 1 == el);
            e.valid = 1'b1;
            e.pix   = pix;
            e.ps    = (m_pcnt == 0);
            e.pe    = last || (ep != 0 && m_pcnt + 1 == ep);
            e.le    = last;
            m_lcnt  = last ? 0 : m_lcnt + 1;
            m_pcnt  = e.pe ? 0 : m_pcnt + 1;
            m_st    = last ? 2 : 1;
        end
        m_armed = arm_now;
        e.issue = 1'b0;
        if (rise) begin
            if (m_pend) begin
                e.issue = 1'b1;
                m_shut  = m_lat_s;
                m_col   = m_lat_c;
                m_stage = m_lat_s ? 1 : 0;
            end else if (m_stage == 1) begin
                m_stage = 2;
            end
        end
        if (wr) begin
            m_lat_s = sd; m_lat_c = cm; m_pend = 1'b1;
        end else if (rise) begin
            m_pend = 1'b0;
        end
        e.arm  = m_armed;
        e.err  = m_err;
        e.pend = m_pend;
        e.shut = m_shut;
        e.col  = m_col;
        e.safe = (m_stage == 2);
        return e;
    endfunction

    // one clock: check the result of inputs driven two cycles back, then drive
    task automatic tick(input bit vs_a, input bit hs_a, input bit de_a,
                        input bit wr, input bit sd, input bit cm);
        logic [PIX_W-1:0] pix;
        @(negedge clk);
        if (ok_d2) check_out(exp_d2);
        exp_d2 = exp_d1;
        ok_d2  = ok_d1;
        pix = PIX_W'($urandom);
        vid_vsync    = cfg_vsync_pol ? vs_a : !vs_a;
        vid_hsync    = cfg_hsync_pol ? hs_a : !hs_a;
        vid_de       = cfg_de_pol ? de_a : !de_a;
        vid_pixel    = pix;
        cmd_wr       = wr;
        cmd_shutdown = sd;
        cmd_colmode  = cm;
        exp_d1 = model(vs_a, hs_a, de_a, pix, wr, sd, cm);
        ok_d1  = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset(input bit pv, input bit ph, input bit pd,
                            input int coding, input int line, input int pkt);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_vsync_pol = pv; cfg_hsync_pol = ph; cfg_de_pol = pd;
        cfg_coding  = 3'(coding);
        cfg_line_px = SIZE_W'(line);
        cfg_pkt_px  = SIZE_W'(pkt);
        vid_vsync = !pv; vid_hsync = !ph; vid_de = !pd;
        vid_pixel = '0; cmd_wr = 0; cmd_shutdown = 0; cmd_colmode = 0;
        m_armed = 0; m_prev_vs = 0; m_err = 0; m_pend = 0; m_lat_s = 0; m_lat_c = 0;
        m_shut = 0; m_col = 0; m_st = 0; m_lcnt = 0; m_pcnt = 0; m_stage = 0;
        ok_d1 = 0; ok_d2 = 0;
        repeat (2) @(negedge clk);
        check_out('0);               // reset state (R2)
        rst_n = 1'b1;
    endtask

    // one frame: sync pulse, then lines; mode 0 exact length, 1 random length
    task automatic frame(input int lines, input int mode, input int wr_pct,
                         input bit wr_on_vs);
        int len, el;
        el = effl();
        tick(1, 0, 0, wr_on_vs, 1'($urandom), 1'($urandom));
        tick(1, 0, 0, 0, 0, 0);
        idle(2);
        for (int l = 0; l < lines; l++) begin
            tick(0, 1, 0, 0, 0, 0);
            idle(1 + ($urandom % 2));
            len = (mode == 0) ? el : el - 2 + int'($urandom % 6);
            if (len < 1) len = 1;
            for (int p = 0; p < len; p++) begin
                bit w;
                w = (int'($urandom % 100) < wr_pct);
                tick(0, 0, 1, w, 1'($urandom), 1'($urandom));
            end
            idle(2);
        end
    endtask

    initial begin
        #(8ns * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0;

        // R2: traffic and a command before the first frame edge
        tag = "R2";
        do_reset(1, 1, 1, 2, 8, 3);
        for (int i = 0; i < 6; i++) tick(0, (i == 0), 1, (i == 2), 1'b0, 1'b1);
        idle(3);
        frame(3, 0, 0, 0);
        frame(2, 0, 0, 0);
        idle(3);

        // R1: all control lines active low
        tag = "R1";
        do_reset(0, 0, 0, 1, 7, 4);
        frame(3, 0, 0, 0);
        do_reset(1, 0, 1, 0, 5, 2);
        frame(3, 0, 0, 0);

        // R5: 18-bit tight, line 11 -> 8, segment 6 -> 4
        tag = "R5";
        do_reset(1, 1, 1, 4, 11, 6);
        frame(3, 0, 0, 0);

        // R6: stream coding, segment 5 -> 4; plain code with odd segment
        tag = "R6";
        do_reset(1, 1, 1, 3, 9, 5);
        frame(3, 0, 0, 0);
        do_reset(1, 1, 1, 6, 9, 5);
        frame(2, 0, 0, 0);

        // R7: zero segment size and segment larger than the line
        tag = "R7";
        do_reset(1, 1, 1, 2, 6, 0);
        frame(2, 0, 0, 0);
        do_reset(0, 1, 0, 0, 4, 9);
        frame(2, 0, 0, 0);

        // R4 / R8: random line lengths around the configured one
        tag = "R8";
        do_reset(1, 1, 1, 2, 7, 3);
        for (int f = 0; f < 6; f++) frame(4, 1, 0, 0);
        tag = "R4";
        do_reset(0, 0, 1, 4, 14, 7);
        for (int f = 0; f < 4; f++) frame(3, 1, 0, 0);

        // R9: line 3 under 18-bit tight rounds to zero
        tag = "R9";
        do_reset(1, 1, 1, 4, 3, 2);
        frame(2, 0, 0, 0);

        // R10 / R12: directed shutdown sequence
        tag = "R12";
        do_reset(1, 1, 1, 2, 4, 2);
        frame(1, 0, 0, 0);
        tick(0, 0, 0, 1, 1, 1);                 // write shutdown 1
        idle(2);
        frame(1, 0, 0, 0);                      // forwarded here
        frame(1, 0, 0, 0);                      // safe rises here
        tick(0, 0, 0, 1, 0, 0);                 // cancel
        frame(1, 0, 0, 0);
        frame(1, 0, 0, 0);

        // R11: writes landing on the frame edge cycle
        tag = "R11";
        do_reset(1, 1, 1, 2, 4, 2);
        frame(1, 0, 0, 1);
        frame(1, 0, 0, 1);
        tick(0, 0, 0, 1, 1, 0);
        frame(1, 0, 0, 1);
        frame(1, 0, 0, 0);

        // R10: random command traffic across many frames
        tag = "R10";
        do_reset(0, 0, 0, 3, 10, 3);
        for (int f = 0; f < 12; f++) frame(3, 1, 4, 1'($urandom));

        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule